// File: doc/BRIEF.md
# Host-Clocked Serial Result Reader

This block is the host side of a serial link to a 16-bit sampling converter. The host supplies the serial clock. After a start request, the block waits for the converter's busy line to go high, which signals that a conversion has finished. It then drives a divided serial clock and shifts in the data line, one bit per falling edge. The result arrives as a signed 16-bit word together with a single-cycle done strobe.

A split count K, taken when the start request is accepted, divides the read into two windows. The first K bits are read as soon as the conversion has finished. The clock then stops until busy falls, which marks the start of the next conversion, and the remaining 16 − K bits are read during that conversion. With K = 16 the whole word is read after completion. With K = 0 the whole word is read during the next conversion. If the next conversion starts before the first window has finished, the block raises an overrun flag and carries the read through to the end.

Top module: `serial_read_master`

## Requirements
- R1: While reset is asserted and just after it, the serial clock is low, the done strobe is low, the overrun flag is low and the result is zero.
- R2: The serial clock idles low. While the clock is running, each high phase lasts DIV/2 system cycles, and consecutive rising edges within a window are DIV system cycles apart. DIV is even and at least 4.
- R3: The data line is sampled at each falling serial edge. The first bit sampled is the MSB, and the 16 bits form a two's complement value on the result port.
- R4: For a split count 0 < K < 16, exactly K rising edges occur after busy goes high. The clock then stays low and done stays low until busy goes low. After that the remaining 16 − K edges follow.
- R5: With K = 16 (or any value above 16, which is treated as 16), all 16 edges and the done strobe occur while busy stays high.
- R6: With K = 0, no serial clock edge occurs until busy goes low. The full word is then read.
- R7: done is high for exactly one cycle, in the cycle after the 16th sample, with the serial clock low. The result changes only in a cycle where done is high and holds its value until the next read completes.
- R8: A start request that arrives while a read is in progress is ignored: no extra edges and no extra done strobe follow.
- R9: If busy goes low during the first window before K bits have been read, the overrun flag is set and the read continues through all 16 bits. The flag stays set until the next start request is accepted, which clears it.
- R10: If a start request is accepted while busy is low, no clock edge occurs until busy goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Read request, one cycle wide |
| split_k | input | 5 | Bits to read once the conversion has finished (0 to 16) |
| busy | input | 1 | Converter busy line: low while converting, high when finished |
| sdata | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock driven by the host |
| result | output | 16 | Last complete word, two's complement |
| done | output | 1 | One-cycle strobe when a word completes |
| overrun | output | 1 | The next conversion started before the first window finished |

## Verification
The assertions assume that DIV is even and that busy and sdata are synchronous to the system clock. They also assume that busy moves only at the converter's conversion boundaries, so the overrun flag can be traced back to a low level of busy in the previous cycle. The stimulus respects these assumptions. It changes busy and start only on falling system edges. Its converter model presents the next bit on each rising serial edge, which leaves DIV/2 cycles before the sampling edge. Each read begins with a fresh conversion word, so every done strobe can be matched against exactly one queued expectation.

// File: rtl/serial_read_master.sv
module serial_read_master #(
  parameter int W   = 16,
  parameter int DIV = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(W+1)-1:0]        split_k,
  input  logic                          busy,
  input  logic                          sdata,
  output logic                          sclk,
  output logic signed [W-1:0]           result,
  output logic                          done,
  output logic                          overrun
);
  localparam int NW   = $clog2(W + 1);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] CMAX  = CW'(DIV - 1);
  localparam logic [CW-1:0] CHALF = CW'(HALF);
  localparam logic [NW-1:0] NFULL = NW'(W);

  typedef enum logic [2:0] {S_IDLE, S_WHI, S_RUN1, S_WLO, S_RUN2} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [NW-1:0] nbits, kreg;
  logic [W-1:0]  shreg;

  wire           running = (st == S_RUN1) || (st == S_RUN2);
  wire           fall    = running && (cnt == CHALF);
  wire [NW-1:0]  nb1     = nbits + NW'(1);
  wire [NW-1:0]  kclamp  = (split_k > NFULL) ? NFULL : split_k;
  wire           win1end = (st == S_RUN1) && fall && (nb1 == kreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbits   <= '0;
      kreg    <= '0;
      shreg   <= '0;
      sclk    <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          kreg    <= kclamp;
          nbits   <= '0;
          overrun <= 1'b0;
          st      <= S_WHI;
        end
        S_WHI: if (busy) begin
          cnt <= '0;
          st  <= (kreg == '0) ? S_WLO : S_RUN1;
        end
        S_RUN1, S_RUN2: begin
          cnt <= (cnt == CMAX) ? '0 : cnt + CW'(1);
          if (cnt == '0) sclk <= 1'b1;
          if (fall) begin
            sclk  <= 1'b0;
            shreg <= {shreg[W-2:0], sdata};
            nbits <= nb1;
            if (nb1 == NFULL) begin
              result <= {shreg[W-2:0], sdata};
              done   <= 1'b1;
              st     <= S_IDLE;
            end else if (win1end) begin
              st <= S_WLO;
            end
          end
          if (st == S_RUN1 && !busy && !win1end) begin
            overrun <= 1'b1;
            st      <= S_RUN2;
          end
        end
        S_WLO: if (!busy) begin
          cnt <= '0;
          st  <= S_RUN2;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_read_master_chk #(
  parameter int W   = 16,
  parameter int DIV = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk,
  input logic         busy,
  input logic         done,
  input logic         overrun,
  input logic [W-1:0] result
);
  localparam int HALF = DIV / 2;
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else        hi_cnt <= sclk ? hi_cnt + 32'd1 : 32'd0;
  end

  p_sclk_high_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (hi_cnt < 32'(HALF)));
  p_sclk_high_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 32'(HALF)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sclk);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(!busy));
endmodule

bind serial_read_master serial_read_master_chk #(.W(W), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy),
  .done(done), .overrun(overrun), .result(result)
);

// File: tb/sim_serial_read_master.sv
module sim_serial_read_master;
  localparam int CLK_P = 10;
  localparam int DIV   = 8;
  localparam int W     = 16;

  logic clk = 0, rst_n = 0, start = 0, busy = 0, sdata = 0;
  logic [4:0] split_k = 0;
  wire sclk, done, overrun;
  wire signed [W-1:0] result;

  int total = 0, bad = 0, rises = 0, idx = 0, ndone = 0;
  int cyc = 0, last_rise = -1000, gap_short = 0, gap_ok = 0, hi = 0, hi_err = 0;
  bit finished = 0;
  logic [W-1:0] conv_word = 0;
  logic [W-1:0] expq[$];

  always #(CLK_P/2) clk = ~clk;

  serial_read_master #(.W(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .split_k(split_k), .busy(busy),
    .sdata(sdata), .sclk(sclk), .result(result), .done(done), .overrun(overrun)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // converter model: next bit appears on each rising serial edge
  always @(posedge sclk) begin
    rises++;
    if (cyc - last_rise < DIV) gap_short++;
    if (cyc - last_rise == DIV) gap_ok++;
    last_rise = cyc;
    sdata = (idx < W) ? conv_word[W-1-idx] : 1'b0;
    idx++;
  end

  // monitor: scoreboard pop and clock shape
  always @(negedge clk) begin
    cyc++;
    if (sclk) hi++;
    else if (hi != 0) begin
      if (hi != DIV/2) hi_err++;
      hi = 0;
    end
    if (rst_n && done) begin
      ndone++;
      if (expq.size() == 0) chk(0, "R3 unexpected done", int'(result), 0);
      else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(result == $signed(e), "R3 result", int'(result), int'($signed(e)));
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic new_conv(logic [W-1:0] w, logic b);
    @(negedge clk);
    conv_word = w;
    idx = 0;
    busy = b;
    expq.push_back(w);
  endtask

  task automatic kick(int k);
    @(negedge clk);
    split_k = 5'(k);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(int n0, string tag);
    for (int i = 0; i < 4000 && ndone == n0; i++) @(negedge clk);
    chk(ndone > n0, tag, ndone, n0 + 1);
  endtask

  task automatic split_read(logic [W-1:0] w, int k, string tag);
    int r0, d0;
    new_conv(w, 1'b1);
    r0 = rises; d0 = ndone;
    kick(k);
    cycles((k + 4) * DIV);
    chk(rises - r0 == k, tag, rises - r0, k);
    chk(ndone == d0, tag, ndone - d0, 0);
    chk(sclk == 0, tag, sclk, 0);
    @(negedge clk) busy = 0;
    wait_done(d0, tag);
    cycles(2);
    chk(rises - r0 == W, tag, rises - r0, W);
  endtask

  initial begin
    int r0, d0;
    logic signed [W-1:0] held;
    cycles(5);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(result == 0, "R1 result", int'(result), 0);
    @(negedge clk) rst_n = 1;
    cycles(2);
    chk(sclk == 0, "R1 after reset", sclk, 0);

    // R5: whole word after completion; R2 period
    new_conv(16'h8001, 1'b1);
    r0 = rises; d0 = ndone; gap_ok = 0;
    kick(16);
    wait_done(d0, "R5 done");
    chk(rises - r0 == 16, "R5 edges", rises - r0, 16);
    chk(busy == 1, "R5 busy high", busy, 1);
    chk(gap_ok == 15, "R2 period", gap_ok, 15);
    held = result;
    cycles(30);
    chk(result == held, "R7 hold", int'(result), int'(held));

    // R4: split reads
    split_read(16'h7ABC, 5, "R4 k5");
    split_read(16'h5555, 1, "R4 k1");
    split_read(16'hA5C3, 15, "R4 k15");

    // R6: K = 0
    new_conv(16'hFFFF, 1'b1);
    r0 = rises; d0 = ndone;
    kick(0);
    cycles(20 * DIV);
    chk(rises - r0 == 0, "R6 no edges", rises - r0, 0);
    @(negedge clk) busy = 0;
    wait_done(d0, "R6 done");
    chk(rises - r0 == 16, "R6 edges", rises - r0, 16);

    // R10: start while converting
    new_conv(16'h0102, 1'b0);
    r0 = rises; d0 = ndone;
    kick(16);
    cycles(10 * DIV);
    chk(rises - r0 == 0, "R10 wait busy", rises - r0, 0);
    @(negedge clk) busy = 1;
    wait_done(d0, "R10 done");
    chk(rises - r0 == 16, "R10 edges", rises - r0, 16);

    // R8: start during read ignored
    new_conv(16'h1234, 1'b1);
    r0 = rises; d0 = ndone;
    kick(16);
    cycles(3 * DIV);
    kick(3);
    wait_done(d0, "R8 done");
    cycles(10 * DIV);
    chk(rises - r0 == 16, "R8 edges", rises - r0, 16);
    chk(ndone - d0 == 1, "R8 strobes", ndone - d0, 1);

    // R9: overrun
    new_conv(16'hC0DE, 1'b1);
    r0 = rises; d0 = ndone;
    kick(12);
    cycles(4 * DIV);
    @(negedge clk) busy = 0;
    cycles(2);
    chk(overrun == 1, "R9 set", overrun, 1);
    wait_done(d0, "R9 done");
    chk(rises - r0 == 16, "R9 edges", rises - r0, 16);
    chk(overrun == 1, "R9 sticky", overrun, 1);
    new_conv(16'h0F0F, 1'b1);
    d0 = ndone;
    kick(20);
    cycles(2);
    chk(overrun == 0, "R9 cleared", overrun, 0);
    wait_done(d0, "R5 clamp done");
    chk(busy == 1, "R5 clamp busy", busy, 1);

    cycles(10);
    chk(expq.size() == 0, "R3 queue empty", expq.size(), 0);
    chk(hi_err == 0, "R2 high width", hi_err, 0);
    chk(gap_short == 0, "R2 short period", gap_short, 0);
    chk(sclk == 0, "R2 idle low", sclk, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", ndone, -1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule